// File: doc/BRIEF.md
# Debug Bus Register Target

This block is a small register file that answers on a debug request/acknowledge bus with a full four-phase handshake. The requester drives an address, a write flag and write data together with a request. The target samples all three on the first cycle it sees the request high while idle. It performs the access once and then raises its acknowledge. The acknowledge and the read data stay put until the requester drops the request. The acknowledge falls one cycle later, and the target is then ready for the next request.

The bank has a generic data width. It holds a group of read/write registers starting at address 0 and a group of read-only registers at a configurable base address. Each read-only register holds a constant computed from its index. Every other address is unmapped: it reads as zero, ignores writes and is still acknowledged, so a requester never hangs on a bad address.

Top module: `dbg_reg_target`

## Requirements
- R1: Reset is synchronous and active high. It forces the acknowledge low and the read data to zero, and clears every read/write register to zero.
- R2: A request seen high while the target is idle is accepted on that clock edge. Address, write flag and write data are sampled in that same cycle, and the acknowledge is high from the next cycle on.
- R3: The acknowledge stays high for as long as the request stays high. A held request is never accepted a second time.
- R4: A write is done only on the accepting edge. Changes to address, write flag or write data while the request is held have no effect on any register.
- R5: The acknowledge goes low in the cycle after the edge at which the request is first sampled low.
- R6: Read data does not change while the acknowledge and the request are both high.
- R7: A read/write register at address a (0 <= a < RW_REGS) returns the last value written to it.
- R8: Read-only register k sits at address RO_BASE+k. It always returns a word whose byte lane b (bits 8b+7..8b) equals (0x5A + 8k + b) mod 256. Writes to it are ignored.
- R9: An address that maps to no register reads as all zeros and ignores writes, and the access is still acknowledged.
- R10: A write access returns all zeros on the read data.
- R11: A new request raised after only one idle clock with the request low, following the acknowledge's fall, is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Request from the requester |
| bus_addr | input | ADDR_W | Register address, valid with the request |
| bus_write | input | 1 | 1 = write access, 0 = read access |
| bus_wdata | input | DATA_W | Write data, valid with the request |
| bus_rdata | output | DATA_W | Read data, held while acknowledged |
| bus_ack | output | 1 | Acknowledge |

## Verification
Some rules are checked by assertions on every cycle. These are the handshake sequencing (acknowledge rise, hold and fall), the single acceptance per request, read-data stability while acknowledged, registers changing only on an accepting edge, zero read data for writes, and zero read data for unmapped reads. The address map itself can only be shown by the bench's scenarios. The bench sweeps every address for reads before and after writes. It sends held requests that scramble the bus inputs, runs back-to-back accesses with the minimum idle gap, and applies a reset in the middle of the run. These show which register each address reaches and what value comes back.

// File: rtl/dbg_reg_pkg.sv
package dbg_reg_pkg;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_BUSY = 1'b1
  } hs_state_e;

  localparam int unsigned RO_SEED = 32'd90;

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic bit in_window(int unsigned a, int unsigned base, int unsigned cnt);
    return (a >= base) && (a < base + cnt);
  endfunction

  function automatic int unsigned window_offset(int unsigned a, int unsigned base);
    return a - base;
  endfunction

  // constant byte lane of a read-only register
  function automatic logic [7:0] ro_lane(int unsigned idx, int unsigned lane);
    return 8'((RO_SEED + idx * 8 + lane) % 256);
  endfunction

endpackage

// File: rtl/dbg_hs_ctrl.sv
module dbg_hs_ctrl
  import dbg_reg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic start,
  output logic ack
);

  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      HS_IDLE: if (req)  state_d = HS_BUSY;
      HS_BUSY: if (!req) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HS_IDLE;
    else     state_q <= state_d;
  end

  assign start = (state_q == HS_IDLE) && req;
  assign ack   = (state_q == HS_BUSY);

  // R2
  ack_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack && req) |=> ack);

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && req) |=> ack);

  // R3
  one_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);

  // R5
  ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !req) |=> !ack);

endmodule

// File: rtl/dbg_addr_dec.sv
module dbg_addr_dec
  import dbg_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned RW_REGS = 4,
  parameter int unsigned RO_REGS = 2,
  parameter int unsigned RO_BASE = 16,
  parameter int unsigned RW_IW   = 2,
  parameter int unsigned RO_IW   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              rw_hit,
  output logic [RW_IW-1:0]  rw_idx,
  output logic              ro_hit,
  output logic [RO_IW-1:0]  ro_idx,
  output logic              miss
);

  int unsigned a;

  always_comb begin
    a      = 32'(addr);
    rw_hit = in_window(a, 0, RW_REGS);
    ro_hit = in_window(a, RO_BASE, RO_REGS);
    rw_idx = RW_IW'(a);
    ro_idx = RO_IW'(window_offset(a, RO_BASE));
    miss   = !rw_hit && !ro_hit;
  end

  // R9
  dec_excl_chk: assert final ($onehot({rw_hit, ro_hit, miss}));

endmodule

// File: rtl/dbg_reg_bank.sv
module dbg_reg_bank
  import dbg_reg_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned RW_REGS = 4,
  parameter int unsigned RO_REGS = 2,
  parameter int unsigned RW_IW   = 2,
  parameter int unsigned RO_IW   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              write,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rw_hit,
  input  logic [RW_IW-1:0]  rw_idx,
  input  logic              ro_hit,
  input  logic [RO_IW-1:0]  ro_idx,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned LANES = DATA_W / 8;

  logic [DATA_W-1:0]         rw_q   [RW_REGS];
  logic [DATA_W-1:0]         ro_val [RO_REGS];
  logic [RW_REGS-1:0]        rw_wen;
  logic [RW_REGS*DATA_W-1:0] rw_flat;
  logic [DATA_W-1:0]         rd_mux;

  for (genvar i = 0; i < RW_REGS; i++) begin : g_rw
    assign rw_wen[i] = start && write && rw_hit && (32'(rw_idx) == i);
    assign rw_flat[i*DATA_W +: DATA_W] = rw_q[i];
  end

  for (genvar k = 0; k < RO_REGS; k++) begin : g_ro
    for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign ro_val[k][b*8 +: 8] = ro_lane(k, b);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < RW_REGS; i++) begin
      if (rst)            rw_q[i] <= '0;
      else if (rw_wen[i]) rw_q[i] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rw_hit)      rd_mux = rw_q[rw_idx];
    else if (ro_hit) rd_mux = ro_val[ro_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (start) rdata <= write ? '0 : rd_mux;
  end

  // R4
  reg_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(rw_flat));

  // R10
  wr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start && write) |=> (rdata == '0));

endmodule

// File: rtl/dbg_reg_target.sv
module dbg_reg_target
  import dbg_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned RW_REGS = 4,
  parameter int unsigned RO_REGS = 2,
  parameter int unsigned RO_BASE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack
);

  localparam int unsigned RW_IW = idx_width(RW_REGS);
  localparam int unsigned RO_IW = idx_width(RO_REGS);

  logic             start;
  logic             rw_hit, ro_hit, miss;
  logic [RW_IW-1:0] rw_idx;
  logic [RO_IW-1:0] ro_idx;

  dbg_hs_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .req   (bus_req),
    .start (start),
    .ack   (bus_ack)
  );

  dbg_addr_dec #(
    .ADDR_W (ADDR_W), .RW_REGS (RW_REGS), .RO_REGS (RO_REGS),
    .RO_BASE(RO_BASE), .RW_IW (RW_IW), .RO_IW (RO_IW)
  ) u_dec (
    .addr   (bus_addr),
    .rw_hit (rw_hit),
    .rw_idx (rw_idx),
    .ro_hit (ro_hit),
    .ro_idx (ro_idx),
    .miss   (miss)
  );

  dbg_reg_bank #(
    .DATA_W (DATA_W), .RW_REGS (RW_REGS), .RO_REGS (RO_REGS),
    .RW_IW  (RW_IW), .RO_IW (RO_IW)
  ) u_bank (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .write  (bus_write),
    .wdata  (bus_wdata),
    .rw_hit (rw_hit),
    .rw_idx (rw_idx),
    .ro_hit (ro_hit),
    .ro_idx (ro_idx),
    .rdata  (bus_rdata)
  );

  // R6
  rdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ack && bus_req) |=> $stable(bus_rdata));

  // R9
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !bus_write && miss) |=> (bus_rdata == '0));

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!bus_ack && bus_rdata == '0));

endmodule

// File: tb/test_dbg_reg_target.sv
module test_dbg_reg_target;

  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 64;
  localparam int RW_REGS = 4;
  localparam int RO_REGS = 2;
  localparam int RO_BASE = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              we = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              ack;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dbg_reg_target #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW_REGS(RW_REGS),
    .RO_REGS(RO_REGS), .RO_BASE(RO_BASE)
  ) i_dbg_reg_target (
    .clk(clk), .rst(rst), .bus_req(req), .bus_addr(addr),
    .bus_write(we), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ack(ack)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_ro(int k);
    logic [63:0] w = '0;
    for (int b = 7; b >= 0; b--) w = (w << 8) | 64'((90 + 8 * k + b) % 256);
    return w;
  endfunction

  function automatic logic [63:0] pat(int a);
    return {8{8'(a)}} ^ 64'hF0E1D2C3B4A59687;
  endfunction

  function automatic logic [63:0] exp_read(int a, bit written);
    if (a < RW_REGS) return written ? pat(a) : 64'd0;
    if (a >= RO_BASE && a < RO_BASE + RO_REGS) return exp_ro(a - RO_BASE);
    return 64'd0;
  endfunction

  // one full four-phase access; returns read data seen with the acknowledge
  task automatic xact(input int a, input bit w, input logic [63:0] d,
                      input int hold, input bit scramble,
                      output logic [63:0] rd);
    @(negedge clk);
    addr = 8'(a); we = w; wdata = d; req = 1'b1;
    @(negedge clk);
    check(ack === 1'b1, "R2 R11 ack after accept", 64'(ack), 64'd1);
    rd = rdata;
    for (int k = 0; k < hold; k++) begin
      if (scramble) begin addr = ~addr; wdata = ~wdata; we = ~we; end
      @(negedge clk);
      check(ack === 1'b1, "R3 ack held", 64'(ack), 64'd1);
      check(rdata === rd, "R6 rdata stable", rdata, rd);
    end
    req = 1'b0; we = 1'b0;
    @(negedge clk);
    check(ack === 1'b0, "R5 ack fall", 64'(ack), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(ack === 1'b0, "R1 ack after reset", 64'(ack), 64'd0);
    check(rdata === '0, "R1 rdata after reset", rdata, 64'd0);

    // sweep reads before any write
    for (int a = 0; a < 256; a++) begin
      xact(a, 1'b0, '0, 0, 1'b0, rd);
      check(rd === exp_read(a, 1'b0), "R1 R8 R9 read before write", rd, exp_read(a, 1'b0));
    end
    // write every address
    for (int a = 0; a < 256; a++) begin
      xact(a, 1'b1, pat(a), 0, 1'b0, rd);
      check(rd === '0, "R10 write returns zero", rd, 64'd0);
    end
    // sweep reads after writes
    for (int a = 0; a < 256; a++) begin
      xact(a, 1'b0, '0, 0, 1'b0, rd);
      check(rd === exp_read(a, 1'b1), "R7 R8 R9 read after write", rd, exp_read(a, 1'b1));
    end

    // held write with scrambled inputs: only the sampled value lands
    xact(1, 1'b1, 64'h1122334455667788, 6, 1'b1, rd);
    xact(1, 1'b0, '0, 0, 1'b0, rd);
    check(rd === 64'h1122334455667788, "R4 held write once", rd, 64'h1122334455667788);
    xact(2, 1'b0, '0, 0, 1'b0, rd);
    check(rd === pat(2), "R4 neighbour untouched", rd, pat(2));
    // held read with scrambled address
    xact(RO_BASE + 1, 1'b0, '0, 5, 1'b1, rd);
    check(rd === exp_ro(1), "R8 held read", rd, exp_ro(1));
    xact(0, 1'b0, '0, 4, 1'b1, rd);
    check(rd === pat(0), "R3 R7 held read no repeat", rd, pat(0));

    // reset mid-run clears registers
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int a = 0; a < RW_REGS; a++) begin
      xact(a, 1'b0, '0, 0, 1'b0, rd);
      check(rd === '0, "R1 cleared by reset", rd, 64'd0);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule